// File: doc/BRIEF.md
# Byte-Lane GPIO Port with Software-Driven Two-Wire Bus

This block gives a processor direct, bit-level control of an SMBus/I2C style two-wire bus. It holds three 8-bit lanes that software reaches with single-byte accesses:

- **Lane 0** is a read-only input lane.
- **Lane 1** holds the output values.
- **Lane 2** holds the direction controls.

Bit 0 of the output and direction lanes belongs to the data line (SDA). Bit 1 belongs to the clock line (SCL). Both lines are open-drain: the block only ever pulls a line low or lets it go. No protocol engine is present. Software produces start, stop and data bits by writing the lanes in sequence, and it learns the data line level by reading the input lane.

The three lanes sit in a small window at a programmable base address plus a fixed offset of 0x38. The base comes in on a port from the configuration logic. A write updates state only when it changes the lane it targets. Such a write clears the input lane. A short time later, once the changed pin has settled and passed through the synchronizer, the sampled data line level is merged back into bit 0 of the input lane.

Top module: `smbus_gpio_port`

## Requirements
- R1: After reset all three lanes read 0x00, and neither `sda_pull_low` nor `scl_pull_low` is asserted.
- R2: A read at window offset 1 or 2 returns the output or direction lane. The data appears on `rd_data` with `rd_valid` high one cycle after the request.
- R3: A write at offset 0 changes nothing. The input lane and both pins keep their values.
- R4: A write at offset 1 or 2 whose data differs from the addressed lane stores the data and clears the whole input lane to 0x00. An input-lane read issued in the cycle right after the write returns 0x00.
- R5: A write whose data equals the addressed lane has no effect. No lane changes, no pin changes, and no new line sample is taken.
- R6: `sda_pull_low` is high exactly when direction bit 0 is 1 and output bit 0 is 0. When direction bit 0 is 0, the data line is released.
- R7: The clock level is taken from output bit 1 only on a changing write that leaves direction bit 1 at 1. Otherwise the clock keeps its last level. `scl_pull_low` is high while that level is 0, and the level resets to 1.
- R8: `sda_line` passes through a synchronizer of SYNC_STAGES flops. Bit 0 of the input lane takes the synchronized line level SYNC_STAGES+1 cycles after a changing write. Bits 7..1 of the input lane stay 0.
- R9: The window starts at `win_base` + 0x38 and follows `win_base` as it changes. An access at offset 3 or beyond, or below the window, reads 0xFF and its write is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_base | input | ADDR_W | Programmable window base |
| bus_sel | input | 1 | One-cycle byte access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 8 | Write byte |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Read data valid pulse |
| sda_line | input | 1 | Wired-AND data line level |
| sda_pull_low | output | 1 | Pull the data line low |
| scl_pull_low | output | 1 | Pull the clock line low |

## Verification
The data line is tested in three states: driven low by the block, released with the line idle high, and released while an external device holds it low. Together these show that the input bit reflects the actual line and not the block's own output value. Writes are sent in pairs of a changing write followed by an identical one. Reading the input lane after the identical write shows whether a non-changing write wrongly re-sampled the line.

The clock line is toggled with its direction bit off and then with it on. This separates holding the last level from following the output bit. Accesses just below and just above the window, before and after the base moves, show that decoding is relative to the live base.

// File: rtl/smbgp_pkg.sv
// Package: shared constants for the byte-lane GPIO port.
// Assumes: lane numbering is fixed by the software view (0 in, 1 out, 2 dir).
package smbgp_pkg;
    localparam int LANE_W = 8;
    localparam int NUM_LANES = 3;

    typedef enum logic [1:0] {
        LANE_IN  = 2'd0,
        LANE_OUT = 2'd1,
        LANE_DIR = 2'd2
    } lane_e;

    localparam logic [LANE_W-1:0] MISS_BYTE = 8'hFF;
endpackage

// File: rtl/smbgp_decode.sv
// Module: window decoder. Computes the offset of an access from the live base
// and flags a hit when it lands on one of the three lanes.
// Assumes: the base may change at any time; decode is purely combinational.
module smbgp_decode
    import smbgp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] WIN_OFFSET = 16'h0038
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output lane_e             lane
);
    logic [ADDR_W-1:0] rel;

    // Offset of the access relative to the window start, then range check.
    always_comb begin
        rel  = addr - base - WIN_OFFSET;
        hit  = (rel < ADDR_W'(NUM_LANES));
        lane = lane_e'(rel[1:0]);
    end
endmodule

// File: rtl/smbgp_lanes.sv
// Module: lane register file. Holds input, output and direction lanes, the
// clock level, the deferred line-capture counter and the registered read port.
// Assumes: requests are one-cycle pulses; reads and writes never overlap.
module smbgp_lanes
    import smbgp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic              hit,
    input  lane_e             lane,
    input  logic [LANE_W-1:0] wdata,
    input  logic              sda_sync,
    output logic [LANE_W-1:0] out_lane,
    output logic [LANE_W-1:0] dir_lane,
    output logic              scl_level,
    output logic [LANE_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int CAP_LOAD = SYNC_STAGES + 1;
    localparam int CAP_W    = $clog2(CAP_LOAD + 1);

    logic [LANE_W-1:0] in_q, out_q, dir_q, rdata_q, lane_cur, next_out, next_dir;
    logic [CAP_W-1:0]  cap_q;
    logic              scl_q, rdv_q, wr_change;

    // Select the currently addressed lane for compare and readback.
    always_comb begin
        case (lane)
            LANE_OUT: lane_cur = out_q;
            LANE_DIR: lane_cur = dir_q;
            default:  lane_cur = in_q;
        endcase
    end

    // Detect a write that actually changes a writable lane, and form next lanes.
    always_comb begin
        wr_change = acc_wr && hit && (lane != LANE_IN) && (wdata != lane_cur);
        next_out  = (wr_change && lane == LANE_OUT) ? wdata : out_q;
        next_dir  = (wr_change && lane == LANE_DIR) ? wdata : dir_q;
    end

    // Lane state, clock level and deferred capture of the synchronized line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q  <= '0;
            out_q <= '0;
            dir_q <= '0;
            scl_q <= 1'b1;
            cap_q <= '0;
        end else if (wr_change) begin
            out_q <= next_out;
            dir_q <= next_dir;
            in_q  <= '0;
            cap_q <= CAP_W'(CAP_LOAD);
            if (next_dir[1]) scl_q <= next_out[1];
        end else if (cap_q != '0) begin
            cap_q <= cap_q - 1'b1;
            if (cap_q == CAP_W'(1)) in_q[0] <= sda_sync;
        end
    end

    // Registered read port; misses return the all-ones byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            rdv_q   <= 1'b0;
        end else begin
            rdv_q <= acc_rd;
            if (acc_rd) rdata_q <= hit ? lane_cur : MISS_BYTE;
        end
    end

    assign out_lane  = out_q;
    assign dir_lane  = dir_q;
    assign scl_level = scl_q;
    assign rd_data   = rdata_q;
    assign rd_valid  = rdv_q;

    // Offset-0 write leaves output and direction lanes alone.
    assert_in_ro_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && hit && lane == LANE_IN) |=> ($stable(out_q) && $stable(dir_q) && $stable(scl_q)));
    // A changing write empties the input lane on the next cycle.
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_change |=> (in_q == '0));
    // A write equal to the lane contents changes no state.
    assert_same_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && hit && lane != LANE_IN && wdata == lane_cur)
        |=> ($stable(out_q) && $stable(dir_q) && $stable(scl_q)));
    // Clock level moves only on a changing write.
    assert_scl_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_change |=> $stable(scl_q));
    // Upper input bits never become set.
    assert_in_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_q[LANE_W-1:1] == '0);
    // Capture counter stays within its load value.
    assert_cap_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q <= CAP_W'(CAP_LOAD));
    // Out-of-window reads return the miss byte.
    assert_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && !hit) |=> (rd_valid && rd_data == MISS_BYTE));
endmodule

// File: rtl/smbgp_pins.sv
// Module: pin stage. Synchronizes the wired-AND data line and forms the
// open-drain pull-low controls from the registered lanes.
// Assumes: the external line is asynchronous and idles high; reset value 1.
module smbgp_pins #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_line,
    input  logic sda_out_bit,
    input  logic sda_dir_bit,
    input  logic scl_level,
    output logic sda_sync,
    output logic sda_pull_low,
    output logic scl_pull_low
);
    logic [SYNC_STAGES-1:0] sync_q;

    // Flop chain bringing the line into the clock domain.
    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[i] <= 1'b1;
                else        sync_q[i] <= (i == 0) ? sda_line : sync_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    // Open-drain controls: pull only when enabled and driving zero.
    always_comb begin
        sda_pull_low = sda_dir_bit && !sda_out_bit;
        scl_pull_low = !scl_level;
    end

    assign sda_sync = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/smbus_gpio_port.sv
// Module: top of the byte-lane GPIO port with software-driven two-wire bus.
// Assumes: single-byte accesses only, one request per cycle at most.
module smbus_gpio_port
    import smbgp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] WIN_OFFSET = 16'h0038,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] win_base,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    input  logic              sda_line,
    output logic              sda_pull_low,
    output logic              scl_pull_low
);
    logic              hit, sda_sync, scl_level, acc_rd, acc_wr;
    lane_e             lane;
    logic [LANE_W-1:0] out_lane, dir_lane;

    // Split the request strobe into read and write pulses.
    always_comb begin
        acc_rd = bus_sel && !bus_we;
        acc_wr = bus_sel && bus_we;
    end

    smbgp_decode #(.ADDR_W(ADDR_W), .WIN_OFFSET(WIN_OFFSET)) u_decode (
        .base(win_base), .addr(bus_addr), .hit(hit), .lane(lane)
    );

    smbgp_lanes #(.SYNC_STAGES(SYNC_STAGES)) u_lanes (
        .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
        .hit(hit), .lane(lane), .wdata(bus_wdata), .sda_sync(sda_sync),
        .out_lane(out_lane), .dir_lane(dir_lane), .scl_level(scl_level),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    smbgp_pins #(.SYNC_STAGES(SYNC_STAGES)) u_pins (
        .clk(clk), .rst_n(rst_n), .sda_line(sda_line),
        .sda_out_bit(out_lane[0]), .sda_dir_bit(dir_lane[0]),
        .scl_level(scl_level), .sda_sync(sda_sync),
        .sda_pull_low(sda_pull_low), .scl_pull_low(scl_pull_low)
    );

    // Turning data direction off releases the data line next cycle.
    assert_sda_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && hit && lane == LANE_DIR && !bus_wdata[0]) |=> !sda_pull_low);
    // Reads always answer exactly one cycle later.
    assert_rd_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> rd_valid);
    // A miss write leaves both pins untouched.
    assert_miss_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && !hit) |=> ($stable(sda_pull_low) && $stable(scl_pull_low)));
endmodule

// File: tb/smbus_gpio_port_test.sv
module smbus_gpio_port_test;
    localparam int AW = 16;
    logic clk = 0, rst_n = 0, bus_sel = 0, bus_we = 0, dev_low = 0;
    logic [AW-1:0] win_base = 16'h0400, bus_addr = '0;
    logic [7:0] bus_wdata = '0, rd_data;
    logic rd_valid, sda_pull_low, scl_pull_low, sda_line;
    int checks = 0, errors = 0;
    logic [7:0] exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;
    assign sda_line = !(sda_pull_low || dev_low);

    smbus_gpio_port uut (
        .clk(clk), .rst_n(rst_n), .win_base(win_base), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .sda_line(sda_line),
        .sda_pull_low(sda_pull_low), .scl_pull_low(scl_pull_low)
    );

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string t);
        @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk); bus_sel = 0;
    endtask

    task automatic pins(input logic s, input logic c, input string t);
        checks++;
        if (sda_pull_low !== s || scl_pull_low !== c) begin
            errors++;
            $display("FAIL %s pins sda/scl=%b%b expected %b%b", t, sda_pull_low, scl_pull_low, s, c);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    // Monitor: compare each read result with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++; $display("FAIL R2 unexpected read %h", rd_data);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (rd_data !== e) begin
                    errors++; $display("FAIL %s read %h expected %h", t, rd_data, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        errors++; $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic logic [AW-1:0] at(input int off);
        return win_base + 16'h0038 + AW'(off);
    endfunction

    initial begin
        repeat (3) @(negedge clk); rst_n = 1;
        pins(0, 0, "R1");
        rd(at(0), 8'h00, "R1"); rd(at(1), 8'h00, "R1"); rd(at(2), 8'h00, "R1");
        // Enable both lines with outputs 0: both pulled low.
        wr(at(2), 8'h03); pins(1, 1, "R6 R7");
        rd(at(0), 8'h00, "R4"); settle();
        // Release both lines: line high sampled into bit 0.
        wr(at(1), 8'h03); pins(0, 0, "R6 R7");
        rd(at(0), 8'h00, "R4"); settle();
        rd(at(0), 8'h01, "R8"); rd(at(1), 8'h03, "R2"); rd(at(2), 8'h03, "R2");
        // Device holds data low while block releases it.
        dev_low = 1; wr(at(1), 8'h83); settle(); dev_low = 0;
        rd(at(0), 8'h00, "R8");
        // Identical write: no resample even though line is now high.
        wr(at(1), 8'h83); settle(); pins(0, 0, "R5");
        rd(at(0), 8'h00, "R5"); rd(at(1), 8'h83, "R5");
        // Offset 0 write ignored.
        wr(at(0), 8'h55); settle(); rd(at(0), 8'h00, "R3"); pins(0, 0, "R3");
        // Clock direction off: clock holds.
        wr(at(2), 8'h01); settle(); pins(0, 0, "R7");
        wr(at(1), 8'h81); settle(); pins(0, 0, "R7");
        wr(at(1), 8'h80); settle(); pins(1, 0, "R6");
        rd(at(0), 8'h00, "R8");
        wr(at(2), 8'h03); settle(); pins(1, 1, "R7");
        // Data direction off with output 0: released, line read high.
        wr(at(2), 8'h02); settle(); pins(0, 1, "R6");
        rd(at(0), 8'h01, "R8");
        // Window boundaries.
        rd(at(3), 8'hFF, "R9"); rd(at(-1), 8'hFF, "R9");
        wr(at(3), 8'h00); wr(at(-1), 8'h00); settle(); pins(0, 1, "R9");
        rd(at(2), 8'h02, "R9"); rd(at(1), 8'h80, "R9");
        win_base = 16'h1200; @(negedge clk);
        rd(at(1), 8'h80, "R9"); rd(16'h0439, 8'hFF, "R9");
        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++; $display("FAIL R2 %0d reads missing, expected 0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule